// File: doc/BRIEF.md
# Bit-Parallel Distributed Arithmetic Dot Product

This block forms the dot product of a group of NUM_TAPS input samples with a fixed set of coefficients, and it uses no multipliers. When the block is built, it fills a small lookup table with the sum of every subset of the coefficients. Bit i of each sample is gathered into an address, and that address selects the subset sum belonging to bit position i. A separate copy of the table serves each bit position, so the lookups for all positions happen in the same cycle.

The table outputs pass through a registered tree. Its first level weights each partial sum by 2^i. In two's complement mode it negates the partial sum from the sign position. Each later level adds pairs of values. A new group of samples can be accepted on every cycle. A valid flag travels with each group and marks the matching result. Chaining several groups into a long filter is left to the surrounding logic.

Top module: `da_sop`

## Requirements
- R1: While rst_n is low and during the first cycles after it rises, out_valid is 0 and out_sum is 0.
- R2: With SIGNED_IN=1, out_sum equals the sum over k of c_k*x_k. Sample x_k is in_samples[k*SAMPLE_W +: SAMPLE_W], read as two's complement. Coefficient c_k is COEF_VEC[k*COEF_W +: COEF_W], also two's complement.
- R3: With SIGNED_IN=0, the samples are read as unsigned integers, and the result follows the same formula as R2.
- R4: A group sampled with in_valid=1 produces out_valid=1 exactly LAT = 1 + ceil(log2(SAMPLE_W)) cycles later. The matching out_sum is present in that same cycle.
- R5: One group is accepted on every cycle with no gaps. The number of out_valid pulses equals the number of accepted groups.
- R6: A cycle with in_valid=0 produces out_valid=0 LAT cycles later, whatever the value of in_samples.
- R7: Table entry addr holds the sum of the c_k whose bit k of addr is 1. An all-zero address reads 0. An input with only x_k=1 (all other samples 0) yields c_k.
- R8: When every sample is at its most negative value, the result is -2^(SAMPLE_W-1) times the sum of all coefficients. This case checks the negated sign-position term.
- R9: A valid out_sum never exceeds NUM_TAPS*2^(COEF_W-1+SAMPLE_W) in magnitude, so the output width never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks in_samples as a group to process |
| in_samples | input | NUM_TAPS*SAMPLE_W | Packed samples; sample k at bits k*SAMPLE_W |
| out_valid | output | 1 | Marks out_sum as a finished result |
| out_sum | output | OUT_W | Dot product, two's complement |

## Verification
A wrong table entry appears LAT cycles after the first input whose bit slice selects that entry. It shows up as an output error of that entry's error times a power of two. A sweep over every sample combination hits every entry at every bit position, so such an error cannot go unseen. A missing sign negation or wrong shift weight corrupts every group in which the affected bit is set. A wrong stage count shifts out_valid off its expected cycle on the first group.

// File: rtl/da_sop_pkg.sv
package da_sop_pkg;
    // Width of one subset sum of NUM_TAPS signed coefficients
    function automatic int psum_width(input int taps, input int cw);
        return cw + $clog2(taps) + 1;
    endfunction

    // Depth of the pipelined add tree for a given number of bit slices
    function automatic int tree_levels(input int slices);
        return $clog2(slices);
    endfunction
endpackage

// File: rtl/da_slice_rom.sv
module da_slice_rom #(
    parameter int NUM_TAPS = 4,
    parameter int COEF_W   = 8,
    parameter int PSUM_W   = 11,
    parameter logic [NUM_TAPS*COEF_W-1:0] COEF_VEC = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_TAPS-1:0]      addr,
    output logic signed [PSUM_W-1:0] psum
);
    localparam int DEPTH = 1 << NUM_TAPS;

    function automatic logic signed [PSUM_W-1:0] subset_sum(input int sel);
        logic signed [PSUM_W-1:0] acc;
        acc = '0;
        for (int k = 0; k < NUM_TAPS; k++) begin
            if (sel[k]) acc += PSUM_W'($signed(COEF_VEC[k*COEF_W +: COEF_W]));
        end
        return acc;
    endfunction

    logic signed [PSUM_W-1:0] table_q [DEPTH];

    genvar a;
    generate
        for (a = 0; a < DEPTH; a++) begin : g_entry
            assign table_q[a] = subset_sum(a);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psum <= '0;
        else        psum <= table_q[addr];
    end

    // R7: an empty subset reads as zero
    a_r7_rom_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == '0) |=> (psum == '0));

    genvar t;
    generate
        for (t = 0; t < NUM_TAPS; t++) begin : g_chk
            // R7: a single selected tap reads back its own coefficient
            a_r7_rom_single: assert property (@(posedge clk) disable iff (!rst_n)
                (addr == NUM_TAPS'(1 << t)) |=>
                (psum == PSUM_W'($signed(COEF_VEC[t*COEF_W +: COEF_W]))));
        end
    endgenerate
endmodule

// File: rtl/da_shift_add_tree.sv
module da_shift_add_tree #(
    parameter int NUM_IN    = 8,
    parameter int IN_W      = 11,
    parameter int ACC_W     = 20,
    parameter bit SIGNED_IN = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [NUM_IN*IN_W-1:0]  psum_flat,
    output logic                    out_valid,
    output logic signed [ACC_W-1:0] out_sum
);
    localparam int LEVELS = da_sop_pkg::tree_levels(NUM_IN);
    localparam int NPOW   = 1 << LEVELS;

    genvar l, j;
    generate
        for (l = 0; l <= LEVELS; l++) begin : g_lvl
            logic signed [ACC_W-1:0] node [NPOW >> l];
            logic                    vld;

            if (l == 0) begin : g_leaf
                for (j = 0; j < NPOW; j++) begin : g_w
                    if (j < NUM_IN) begin : g_used
                        logic signed [ACC_W-1:0] ext;
                        assign ext = ACC_W'($signed(psum_flat[j*IN_W +: IN_W]));
                        if (SIGNED_IN && (j == NUM_IN - 1)) begin : g_neg
                            assign node[j] = -(ext <<< j);
                        end else begin : g_pos
                            assign node[j] = ext <<< j;
                        end
                    end else begin : g_pad
                        assign node[j] = '0;
                    end
                end
                assign vld = in_valid;
            end else begin : g_add
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        vld <= 1'b0;
                        for (int n = 0; n < (NPOW >> l); n++) node[n] <= '0;
                    end else begin
                        vld <= g_lvl[l-1].vld;
                        for (int n = 0; n < (NPOW >> l); n++)
                            node[n] <= g_lvl[l-1].node[2*n] + g_lvl[l-1].node[2*n+1];
                    end
                end
            end
        end
    endgenerate

    assign out_sum   = g_lvl[LEVELS].node[0];
    assign out_valid = g_lvl[LEVELS].vld;
endmodule

// File: rtl/da_sop.sv
module da_sop #(
    parameter int NUM_TAPS  = 4,
    parameter int SAMPLE_W  = 8,
    parameter int COEF_W    = 8,
    parameter bit SIGNED_IN = 1'b1,
    parameter logic [NUM_TAPS*COEF_W-1:0] COEF_VEC = {8'd23, 8'hC3, 8'd100, 8'hF9},
    parameter int OUT_W     = COEF_W + SAMPLE_W + $clog2(NUM_TAPS) + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [NUM_TAPS*SAMPLE_W-1:0] in_samples,
    output logic                         out_valid,
    output logic [OUT_W-1:0]             out_sum
);
    localparam int PSUM_W = da_sop_pkg::psum_width(NUM_TAPS, COEF_W);
    localparam int LAT    = 1 + da_sop_pkg::tree_levels(SAMPLE_W);
    localparam longint BOUND = longint'(NUM_TAPS) <<< (COEF_W - 1 + SAMPLE_W);

    logic [SAMPLE_W*PSUM_W-1:0] psum_flat;
    logic                       rom_vld;
    logic signed [OUT_W-1:0]    tree_sum;

    genvar i, k;
    generate
        for (i = 0; i < SAMPLE_W; i++) begin : g_slice
            logic [NUM_TAPS-1:0]      slice_addr;
            logic signed [PSUM_W-1:0] slice_psum;
            for (k = 0; k < NUM_TAPS; k++) begin : g_bit
                assign slice_addr[k] = in_samples[k*SAMPLE_W + i];
            end
            da_slice_rom #(
                .NUM_TAPS (NUM_TAPS),
                .COEF_W   (COEF_W),
                .PSUM_W   (PSUM_W),
                .COEF_VEC (COEF_VEC)
            ) rom_i (
                .clk   (clk),
                .rst_n (rst_n),
                .addr  (slice_addr),
                .psum  (slice_psum)
            );
            assign psum_flat[i*PSUM_W +: PSUM_W] = slice_psum;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rom_vld <= 1'b0;
        else        rom_vld <= in_valid;
    end

    da_shift_add_tree #(
        .NUM_IN    (SAMPLE_W),
        .IN_W      (PSUM_W),
        .ACC_W     (OUT_W),
        .SIGNED_IN (SIGNED_IN)
    ) tree_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rom_vld),
        .psum_flat (psum_flat),
        .out_valid (out_valid),
        .out_sum   (tree_sum)
    );

    assign out_sum = tree_sum;

    // R1: reset empties the pipeline
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R4: accepted group appears after exactly LAT cycles
    a_r4_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##LAT out_valid);

    // R6: idle cycle yields no result
    a_r6_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##LAT !out_valid);

    // R2: all-zero samples give a zero result
    a_r2_zero_in: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_samples == '0) |-> ##LAT (out_sum == '0));

    // R9: valid result stays inside the representable range
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (longint'($signed(out_sum)) <= BOUND &&
                       longint'($signed(out_sum)) >= -BOUND));
endmodule

// File: tb/da_sop_tb_top.sv
module da_sop_tb_top;
    localparam int K    = 4;
    localparam int W    = 4;
    localparam int C    = 6;
    localparam int LAT  = 3;
    localparam int OW   = C + W + 2 + 1;
    localparam int NVEC = 1 << (K*W);
    localparam int NCYC = NVEC + LAT + 2;
    localparam logic [K*C-1:0] CVEC = {6'h33, 6'd7, 6'h20, 6'd31};

    int coef [K] = '{31, -32, 7, -13};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [K*W-1:0] in_samples = '0;
    logic          ov_s, ov_u;
    logic [OW-1:0] os_s, os_u;

    int checks = 0;
    int errors = 0;
    int exp_s [NCYC];
    int exp_u [NCYC];
    bit exp_v [NCYC];
    int cat   [NCYC];
    int n_in = 0;
    int n_out = 0;

    always #5 clk = ~clk;

    da_sop #(.NUM_TAPS(K), .SAMPLE_W(W), .COEF_W(C), .SIGNED_IN(1'b1),
             .COEF_VEC(CVEC), .OUT_W(OW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
        .out_valid(ov_s), .out_sum(os_s));

    da_sop #(.NUM_TAPS(K), .SAMPLE_W(W), .COEF_W(C), .SIGNED_IN(1'b0),
             .COEF_VEC(CVEC), .OUT_W(OW)) dut_u (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
        .out_valid(ov_u), .out_sum(os_u));

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic string sum_tag(input int c);
        if (c == 1) return "R7";
        if (c == 2) return "R8";
        return "R2";
    endfunction

    initial begin
        repeat (3) begin
            @(negedge clk);
            chk("R1 valid signed", int'(ov_s), 0);
            chk("R1 valid unsigned", int'(ov_u), 0);
            chk("R1 sum signed", int'($signed(os_s)), 0);
            chk("R1 sum unsigned", int'($signed(os_u)), 0);
        end
        rst_n = 1'b1;
        for (int c = 0; c < NCYC; c++) begin
            @(negedge clk);
            if (ov_s) n_out++;
            if (c < LAT) begin
                chk("R1 valid after release", int'(ov_s), 0);
            end else begin
                int d;
                d = c - LAT;
                chk(exp_v[d] ? "R4 valid signed" : "R6 valid signed", int'(ov_s), int'(exp_v[d]));
                chk(exp_v[d] ? "R4 valid unsigned" : "R6 valid unsigned", int'(ov_u), int'(exp_v[d]));
                if (exp_v[d]) begin
                    chk(sum_tag(cat[d]), int'($signed(os_s)), exp_s[d]);
                    chk("R3", int'($signed(os_u)), exp_u[d]);
                end
            end
            if (c < NVEC) begin
                int es, eu, nz, ones;
                logic [K*W-1:0] v;
                v = (K*W)'(c);
                es = 0; eu = 0; nz = 0; ones = 0;
                for (int k = 0; k < K; k++) begin
                    logic [W-1:0] f;
                    f = v[k*W +: W];
                    es += coef[k] * int'($signed(f));
                    eu += coef[k] * int'(f);
                    if (f != 0) nz++;
                    if (f == 1) ones++;
                end
                in_samples = v;
                in_valid   = ((c % 11) != 5);
                if (in_valid) n_in++;
                exp_s[c] = es;
                exp_u[c] = eu;
                exp_v[c] = in_valid;
                cat[c]   = (nz == 1 && ones == 1) ? 1 : (v == 16'h8888 ? 2 : 0);
            end else begin
                in_valid   = 1'b0;
                in_samples = '1;
                exp_v[c]   = 1'b0;
                cat[c]     = 0;
            end
        end
        chk("R5 pulse count", n_out, n_in);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule